// File: doc/BRIEF.md
# Bus Snoop Capture Queue

This block watches a 32-bit parallel port on every clock and compares the port word, after an AND with a mask, against a compare value. On a hit it stores the whole port word, including the bits the mask hides, as a four-byte record in a byte-wide circular queue. After a capture the detector stays quiet until the port word changes in any bit, so a pattern that stays on the port is recorded once and not on every cycle.

A host drains the queue over a byte-oriented SPI slave. Each byte the host sends is a command. The reply to that command comes back in the byte that follows. The available commands report how many bytes are queued, pop the oldest byte, or read and clear a sticky flag that marks records lost to a full queue. Snooping continues while the host is reading, so a capture can land in the middle of a transfer.

Top module: `snoop_queue_top`

## Requirements
- R1: When (bus_port AND match_mask) equals match_value while the detector is armed, the full bus_port word is queued as four bytes, least significant byte first.
- R2: After a capture the detector is disarmed. It re-arms one cycle after bus_port differs in any bit from the captured word, bits outside match_mask included. A word that is held on the port is captured only once.
- R3: The queue has 256 byte slots. Its read and write pointers are 8 bits wide and wrap from 255 to 0. The byte count is the write pointer minus the read pointer, modulo 256.
- R4: A capture is accepted only when the byte count is 251 or less. Otherwise the record is dropped and the overflow flag is set. The flag stays set until it is read.
- R5: Command code 2 returns 0x01 if the overflow flag is set and 0x00 if it is not, then clears the flag. A drop in the same cycle as the clear leaves the flag set.
- R6: Command code 1 returns the oldest queued byte and removes it. On an empty queue it returns 0x00 and leaves the queue unchanged.
- R7: Command code 0 returns the current byte count.
- R8: SPI uses mode 0 (sample on rising SCLK, shift on falling SCLK), MSB first, with chip select active low. The reply to a command byte is shifted out during the next byte. Only bits 3:0 of a command byte are decoded. Codes 3 to 15 return 0xFF.
- R9: A capture that occurs while an SPI transfer is in progress is still queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_port | input | 32 | Snooped bus word |
| match_mask | input | 32 | Bits taking part in the comparison |
| match_value | input | 32 | Value the masked word must equal |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |

## Verification
The checker holds several properties on every cycle. A queue write never occurs while the count is above 251, and two writes are never back to back. A pop never occurs on an empty queue, and a pop without a concurrent write lowers the count by exactly one. The overflow flag rises after a drop and stays set until a clear command. Whether the right word is captured, the order of its bytes, the effect of a change in a bit outside the mask, pointer wrap, and the replies on the serial line can only be seen in the bench scenarios. These scenarios compare each reply against a byte-queue model kept in the bench.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    localparam int unsigned PORT_W_DEF = 32;
    localparam int unsigned AW_DEF     = 8;

    typedef enum logic [3:0] {
        CMD_COUNT = 4'd0,
        CMD_POP   = 4'd1,
        CMD_OVF   = 4'd2
    } cmd_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HOLD  = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic [2:0] bitcnt;
        logic [7:0] rx;
        logic [7:0] tx;
    } spi_regs_t;

    function automatic logic [7:0] reply_byte(
        input logic [3:0] code,
        input logic [7:0] count,
        input logic [7:0] head,
        input logic       ovf
    );
        case (code)
            CMD_COUNT: reply_byte = count;
            CMD_POP:   reply_byte = (count == 8'd0) ? 8'h00 : head;
            CMD_OVF:   reply_byte = {7'd0, ovf};
            default:   reply_byte = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/snoop_capture.sv
module snoop_capture
    import snoop_pkg::*;
#(
    parameter int unsigned PORT_W = PORT_W_DEF,
    parameter int unsigned AW     = AW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] port,
    input  logic [PORT_W-1:0] mask,
    input  logic [PORT_W-1:0] cmp,
    input  logic [AW-1:0]     count,
    output logic              wr_en,
    output logic              ovf_set
);
    localparam int unsigned DEPTH     = 1 << AW;
    localparam int unsigned REC_BYTES = PORT_W / 8;
    localparam int unsigned LIMIT     = DEPTH - 1 - REC_BYTES;

    cap_state_e        state;
    logic [PORT_W-1:0] held;
    logic              hit;
    logic              room;

    always_comb begin
        hit     = (state == ST_ARMED) && ((port & mask) == cmp);
        room    = (count <= AW'(LIMIT));
        wr_en   = hit && room;
        ovf_set = hit && !room;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ARMED;
            held  <= '0;
        end else begin
            case (state)
                ST_ARMED: if (hit) begin
                    state <= ST_HOLD;
                    held  <= port;
                end
                ST_HOLD: if (port != held) state <= ST_ARMED;
                default: state <= ST_ARMED;
            endcase
        end
    end
endmodule

// File: rtl/snoop_ring.sv
module snoop_ring
    import snoop_pkg::*;
#(
    parameter int unsigned PORT_W = PORT_W_DEF,
    parameter int unsigned AW     = AW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_word,
    input  logic              pop_en,
    output logic [AW-1:0]     count,
    output logic [7:0]        head
);
    localparam int unsigned DEPTH     = 1 << AW;
    localparam int unsigned REC_BYTES = PORT_W / 8;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en) begin
                for (int k = 0; k < REC_BYTES; k++) begin
                    mem[wptr + AW'(k)] <= wr_word[k*8 +: 8];
                end
                wptr <= wptr + AW'(REC_BYTES);
            end
            if (pop_en) rptr <= rptr + AW'(1);
        end
    end

    assign count = wptr - rptr;
    assign head  = mem[rptr];
endmodule

// File: rtl/snoop_spi.sv
module snoop_spi
    import snoop_pkg::*;
#(
    parameter int unsigned AW = AW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic [AW-1:0] count,
    input  logic [7:0]    head,
    input  logic          ovf,
    output logic          miso,
    output logic          pop_en,
    output logic          ovf_clr
);
    logic [2:0] sclk_sync;
    logic [1:0] cs_sync;
    logic [1:0] mosi_sync;
    spi_regs_t  r;
    logic       rise;
    logic       fall;
    logic       exec;
    logic [7:0] cmd;
    logic [7:0] count8;

    always_comb begin
        rise    = sclk_sync[1] && !sclk_sync[2] && !cs_sync[1];
        fall    = !sclk_sync[1] && sclk_sync[2] && !cs_sync[1];
        exec    = rise && (r.bitcnt == 3'd7);
        cmd     = {r.rx[6:0], mosi_sync[1]};
        count8  = 8'(count);
        pop_en  = exec && (cmd[3:0] == CMD_POP) && (count != '0);
        ovf_clr = exec && (cmd[3:0] == CMD_OVF);
        miso    = r.tx[7];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sync <= '0;
            cs_sync   <= 2'b11;
            mosi_sync <= '0;
            r         <= '{bitcnt: 3'd0, rx: 8'd0, tx: 8'hFF};
        end else begin
            sclk_sync <= {sclk_sync[1:0], sclk};
            cs_sync   <= {cs_sync[0], cs_n};
            mosi_sync <= {mosi_sync[0], mosi};
            if (cs_sync[1]) begin
                r.bitcnt <= 3'd0;
            end else if (rise) begin
                r.bitcnt <= r.bitcnt + 3'd1;
                r.rx     <= cmd;
                if (exec) r.tx <= reply_byte(cmd[3:0], count8, head, ovf);
            end else if (fall && r.bitcnt != 3'd0) begin
                r.tx <= {r.tx[6:0], 1'b1};
            end
        end
    end
endmodule

// File: rtl/snoop_queue_top.sv
module snoop_queue_top
    import snoop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] bus_port,
    input  logic [31:0] match_mask,
    input  logic [31:0] match_value,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso
);
    localparam int unsigned PORT_W = PORT_W_DEF;
    localparam int unsigned AW     = AW_DEF;

    logic          wr_en;
    logic          ovf_set;
    logic          ovf_clr;
    logic          pop_en;
    logic          ovf;
    logic [AW-1:0] count;
    logic [7:0]    head;

    snoop_capture #(.PORT_W(PORT_W), .AW(AW)) u_cap (
        .clk(clk), .rst(rst), .port(bus_port), .mask(match_mask),
        .cmp(match_value), .count(count), .wr_en(wr_en), .ovf_set(ovf_set)
    );

    snoop_ring #(.PORT_W(PORT_W), .AW(AW)) u_ring (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(bus_port),
        .pop_en(pop_en), .count(count), .head(head)
    );

    snoop_spi #(.AW(AW)) u_spi (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .count(count), .head(head), .ovf(ovf),
        .miso(spi_miso), .pop_en(pop_en), .ovf_clr(ovf_clr)
    );

    always_ff @(posedge clk) begin
        if (rst)          ovf <= 1'b0;
        else if (ovf_set) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end
endmodule

// File: rtl/snoop_checker.sv
module snoop_checker #(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          pop_en,
    input logic          ovf_set,
    input logic          ovf_clr,
    input logic          ovf,
    input logic [AW-1:0] count
);
    localparam int unsigned LIMIT = (1 << AW) - 5;

    assert_room_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (count <= AW'(LIMIT)));

    assert_single_capture_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> (count != '0));

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !wr_en) |=> (count == $past(count) - AW'(1)));

    assert_ovf_rise_R4: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> ovf);

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

bind snoop_queue_top snoop_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .pop_en(pop_en),
    .ovf_set(ovf_set), .ovf_clr(ovf_clr), .ovf(ovf), .count(count)
);

// File: tb/tb_snoop_queue_top.sv
module tb_snoop_queue_top;
    localparam int HALF = 8;
    localparam logic [31:0] MASK = 32'h0000_00FF;
    localparam logic [31:0] CMPV = 32'h0000_00A5;
    localparam int NVEC = 7;
    // {capture expected, port word}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 32'h0000_0000},
        {1'b1, 32'h1234_56A5},
        {1'b0, 32'h1234_56A5},
        {1'b1, 32'h1234_57A5},
        {1'b0, 32'h0000_0011},
        {1'b1, 32'hDEAD_BEA5},
        {1'b0, 32'hDEAD_BEA4}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] bus_port = '0;
    logic        spi_sclk = 0;
    logic        spi_cs_n = 1;
    logic        spi_mosi = 0;
    logic        spi_miso;

    int          checks = 0;
    int          fails  = 0;
    logic [7:0]  model [$];
    logic        model_ovf = 0;
    logic [7:0]  resp;
    logic        done = 0;

    always #10 clk = ~clk;

    snoop_queue_top dut (
        .clk(clk), .rst(rst), .bus_port(bus_port), .match_mask(MASK),
        .match_value(CMPV), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            wait_clk(HALF);
            spi_sclk = 1;
            rx[i] = spi_miso;
            wait_clk(HALF);
            spi_sclk = 0;
        end
    endtask

    task automatic spi_cmd(input logic [7:0] c, output logic [7:0] r);
        logic [7:0] junk;
        spi_cs_n = 0;
        wait_clk(HALF);
        spi_byte(c, junk);
        spi_byte(8'hFF, r);
        wait_clk(HALF);
        spi_cs_n = 1;
        wait_clk(HALF);
    endtask

    task automatic model_capture(input logic [31:0] w);
        if (model.size() <= 251) begin
            for (int k = 0; k < 4; k++) model.push_back(w[k*8 +: 8]);
        end else begin
            model_ovf = 1;
        end
    endtask

    // pops n bytes in one frame, each reply arriving in the next byte
    task automatic pop_burst(input int n, input string req);
        logic [7:0] r;
        logic [7:0] exp;
        spi_cs_n = 0;
        wait_clk(HALF);
        spi_byte(8'h01, r);
        for (int i = 0; i < n; i++) begin
            exp = (model.size() != 0) ? model.pop_front() : 8'h00;
            spi_byte((i == n - 1) ? 8'hFF : 8'h01, r);
            check(req, r, exp);
        end
        wait_clk(HALF);
        spi_cs_n = 1;
        wait_clk(HALF);
    endtask

    initial begin
        wait_clk(4000000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst = 0;
        wait_clk(5);

        // reset state: empty queue, flag clear (R7, R5)
        spi_cmd(8'h00, resp); check("R7 reset count", resp, 8'h00);
        spi_cmd(8'h02, resp); check("R5 reset flag", resp, 8'h00);

        // vector walk: R1 capture, R2 hold and re-arm on unmasked bit
        for (int v = 0; v < NVEC; v++) begin
            bus_port = VEC[v][31:0];
            if (VEC[v][32]) model_capture(VEC[v][31:0]);
            wait_clk(6);
            spi_cmd(8'h00, resp);
            check("R1/R2 count after vector", resp, 8'(model.size()));
        end

        // R8: upper nibble ignored, unused codes
        spi_cmd(8'h10, resp); check("R8 upper nibble ignored", resp, 8'(model.size()));
        spi_cmd(8'h05, resp); check("R8 unused code", resp, 8'hFF);
        spi_cmd(8'hEF, resp); check("R8 unused code 15", resp, 8'hFF);

        // R1 byte order, R6 pops
        pop_burst(model.size(), "R1/R6 popped byte");
        spi_cmd(8'h00, resp); check("R7 count after drain", resp, 8'h00);
        spi_cmd(8'h01, resp); check("R6 pop on empty", resp, 8'h00);
        spi_cmd(8'h00, resp); check("R6 empty pop no move", resp, 8'h00);

        // R9: capture during an SPI transfer
        bus_port = 32'h0;
        wait_clk(4);
        fork
            spi_cmd(8'h0F, resp);
            begin
                wait_clk(60);
                bus_port = 32'hCAFE_F0A5;
                model_capture(32'hCAFE_F0A5);
            end
        join
        wait_clk(6);
        spi_cmd(8'h00, resp); check("R9 capture during transfer", resp, 8'h04);
        bus_port = 32'h0;

        // R4 fill to the limit, overflow flag
        for (int i = 1; i <= 70; i++) begin
            bus_port = {i[23:0], 8'hA5};
            model_capture({i[23:0], 8'hA5});
            wait_clk(3);
            bus_port = 32'h0;
            wait_clk(3);
        end
        spi_cmd(8'h00, resp); check("R4 count at limit", resp, 8'(model.size()));
        spi_cmd(8'h02, resp); check("R4/R5 flag set", resp, {7'd0, model_ovf});
        spi_cmd(8'h02, resp); check("R5 flag cleared", resp, 8'h00);

        // R3 drain across the pointer wrap
        pop_burst(model.size(), "R3 wrapped byte");
        spi_cmd(8'h00, resp); check("R3 count after wrap drain", resp, 8'h00);
        bus_port = 32'h8765_43A5;
        model_capture(32'h8765_43A5);
        wait_clk(6);
        pop_burst(4, "R3 record after wrap");
        spi_cmd(8'h00, resp); check("R3 final count", resp, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule